// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine

This block moves the data of one disk command between system memory and a local sector buffer. The host places a chain of 8-byte descriptors in memory, each naming a memory region and its length. The last one carries an end-of-chain flag. The device side arms the engine when it accepts a DMA command, giving the transfer direction and the sector count. The host side then writes the chain's base address with a start strobe.

The engine reads each descriptor over a simple request/acknowledge memory port. It waits a modelled media time for the region, then issues the region as bursts that never cross a page. A busy memory port makes it back off for a fixed number of cycles and retry the same request.

When the flagged region finishes, the engine pulses `done`, the interrupt-status set strobe. `fault` is raised with it if the command's byte budget was not used exactly. A stop request aborts the command at any point. Per-direction counters record bursts, bytes and full-page bursts.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset `mem_req`, `done` and `fault` are 0 and all six counters are 0.
- R2: The first descriptor read uses `table_base` with bits 1:0 forced to zero, length 8 and `mem_we`=0. Each further descriptor is read from the previous address plus 8.
- R3: Descriptor layout: bits 31:0 give the region base, and bits 47:32 give the byte count (a multiple of 512; 0 means 65536). Bit 63 marks the last descriptor.
- R4: `go` is taken only in the cycle after an accepted `arm`, or later. The first descriptor request appears in the cycle after `go`. A `go` with no preceding `arm` produces no request.
- R5: No burst crosses a PAGE_BYTES boundary. The first burst of a region runs to the end of its page or the end of the region. Each following burst is one page, or the remainder if that is shorter.
- R6: Bursts use `mem_we`=1 when `to_mem` was 1 at arm (disk-to-memory), and `mem_we`=0 otherwise.
- R7: With one-cycle acknowledges, the first burst of a region is requested DELAY + count/512 + 2 cycles after its descriptor request. Every other request follows the previous burst request by 2 cycles.
- R8: If `mem_busy` is high in a cycle where a request is due, no request is made. The identical request is due again BACKOFF+1 cycles later.
- R9: `done` pulses for one cycle, two cycles after the last burst of the flagged region is requested. `fault` pulses with it when the bytes moved differ from the armed sectors × 512 (`cmd_sectors`=0 means 256 sectors).
- R10: `stop` while armed or transferring makes `done` and `fault` pulse in the next cycle and returns the engine to idle with no further requests.
- R11: On each burst acknowledge, the counters of its direction (rd_* for memory reads, wr_* for memory writes) add one burst and the burst length in bytes. They add one full-page burst when the length equals PAGE_BYTES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Device accepted a DMA command (taken in idle) |
| to_mem | input | 1 | 1: disk-to-memory (memory writes); 0: memory-to-disk |
| cmd_sectors | input | 8 | Sector count of the command, 0 means 256 |
| go | input | 1 | Start strobe from the bus-master registers |
| table_base | input | 32 | Descriptor chain base address |
| stop | input | 1 | Abort request |
| mem_req | output | 1 | Memory request, one cycle per request |
| mem_we | output | 1 | 1 for a memory write burst |
| mem_addr | output | 32 | Request address |
| mem_len | output | 17 | Request length in bytes |
| mem_busy | input | 1 | Memory port cannot take a request this cycle |
| mem_ack | input | 1 | Response to the outstanding request |
| mem_rdata | input | 64 | Descriptor data returned with `mem_ack` |
| done | output | 1 | Command finished or aborted (interrupt status set) |
| fault | output | 1 | Qualifies `done`: abort or byte-count mismatch |
| rd_bursts | output | CNT_W | Completed memory-read bursts |
| rd_bytes | output | CNT_W | Bytes read from memory |
| rd_pages | output | CNT_W | Memory-read bursts of a full page |
| wr_bursts | output | CNT_W | Completed memory-write bursts |
| wr_bytes | output | CNT_W | Bytes written to memory |
| wr_pages | output | CNT_W | Memory-write bursts of a full page |

## Verification
The properties take for granted that `mem_ack` comes exactly once per issued request, and never while the engine is idle. They also assume every descriptor count is a nonzero multiple of 512 or zero, and that `stop` does not coincide with an issued request. The bench's memory responder answers only the requests it actually sees, always one cycle later, and its descriptor tables hold only legal counts. Stop pulses are placed in delay or armed cycles. Busy is driven as a periodic pattern whose period never lines up with the retry spacing, so a backed-off request is always eventually taken.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
  localparam int ADDR_W       = 32;
  localparam int DESC_W       = 64;
  localparam int DESC_BYTES   = 8;
  localparam int SECT_SHIFT   = 9;
  localparam int MAX_RGN      = 65536;
  localparam int RGN_W        = $clog2(MAX_RGN) + 1;
  localparam int CMD_W        = $clog2(256 * (1 << SECT_SHIFT)) + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ARMED, S_FETCH, S_FWAIT, S_DELAY, S_BURST, S_BWAIT, S_BACK
  } eng_st_e;
endpackage

// File: rtl/prd_chunk.sv
module prd_chunk #(
  parameter int PAGE_BYTES = 4096,
  parameter int RGN_W      = 17,
  localparam int PG_W      = $clog2(PAGE_BYTES)
) (
  input  logic [PG_W-1:0]  offs,
  input  logic [RGN_W-1:0] left,
  output logic [RGN_W-1:0] len
);
  logic [RGN_W-1:0] room;

  assign room = RGN_W'(PAGE_BYTES) - RGN_W'(offs);
  assign len  = (left < room) ? left : room;
endmodule

// File: rtl/prd_countdown.sv
module prd_countdown #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign cnt_en = load || (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)             cnt_d = load_val;
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign last = (cnt_q <= W'(1));
endmodule

// File: rtl/prd_stats.sv
module prd_stats #(
  parameter int PAGE_BYTES = 4096,
  parameter int RGN_W      = 17,
  parameter int CNT_W      = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic [RGN_W-1:0] len,
  output logic [CNT_W-1:0] bursts,
  output logic [CNT_W-1:0] bytes,
  output logic [CNT_W-1:0] pages
);
  logic full;

  assign full = (len == RGN_W'(PAGE_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bursts <= '0;
      bytes  <= '0;
      pages  <= '0;
    end else if (hit) begin
      bursts <= bursts + 1'b1;
      bytes  <= bytes + CNT_W'(len);
      if (full) pages <= pages + 1'b1;
    end
  end
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
  import prd_dma_pkg::*;
#(
  parameter int DELAY      = 4,
  parameter int BACKOFF    = 3,
  parameter int PAGE_BYTES = 4096,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm,
  input  logic              to_mem,
  input  logic [7:0]        cmd_sectors,
  input  logic              go,
  input  logic [ADDR_W-1:0] table_base,
  input  logic              stop,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [RGN_W-1:0]  mem_len,
  input  logic              mem_busy,
  input  logic              mem_ack,
  input  logic [DESC_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [CNT_W-1:0]  rd_bursts,
  output logic [CNT_W-1:0]  rd_bytes,
  output logic [CNT_W-1:0]  rd_pages,
  output logic [CNT_W-1:0]  wr_bursts,
  output logic [CNT_W-1:0]  wr_bytes,
  output logic [CNT_W-1:0]  wr_pages
);
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int DLY_W = $clog2(DELAY + (MAX_RGN >> SECT_SHIFT) + 1) + 1;
  localparam int BO_W  = $clog2(BACKOFF + 1) + 1;

  eng_st_e            st_q, st_d;
  logic [ADDR_W-1:0]  ptr_q, ptr_d, rg_addr_q, rg_addr_d;
  logic [RGN_W-1:0]   rg_left_q, rg_left_d, chunk_len, d_len;
  logic [CMD_W-1:0]   cmd_left_q, cmd_left_d;
  logic               eot_q, eot_d, dir_q, dir_d, back_fetch_q, back_fetch_d;
  logic               done_d, fault_d, dly_load, bo_load, dly_last, bo_last;
  logic               stat_hit, issue_due, in_burst, eng_idle, abort, last_chunk;
  logic [DLY_W-1:0]   dly_val;
  logic               unused_bits;

  assign unused_bits = ^{mem_rdata[62:48], table_base[1:0]};

  // descriptor decode: base 31:0, count 47:32 (0 = 64 KiB), last flag 63
  assign d_len   = (mem_rdata[47:32] == 16'd0) ? RGN_W'(MAX_RGN) : RGN_W'(mem_rdata[47:32]);
  assign dly_val = DLY_W'(DELAY) + DLY_W'(d_len >> SECT_SHIFT);

  assign eng_idle   = (st_q == S_IDLE);
  assign in_burst   = (st_q == S_BURST);
  assign issue_due  = (st_q == S_FETCH) || in_burst;
  assign abort      = stop && !eng_idle;
  assign last_chunk = (chunk_len == rg_left_q);

  assign mem_req  = issue_due && !mem_busy;
  assign mem_we   = in_burst && dir_q;
  assign mem_addr = in_burst ? rg_addr_q : ptr_q;
  assign mem_len  = in_burst ? chunk_len : RGN_W'(DESC_BYTES);

  prd_chunk #(.PAGE_BYTES(PAGE_BYTES), .RGN_W(RGN_W)) u_chunk (
    .offs(rg_addr_q[PG_W-1:0]), .left(rg_left_q), .len(chunk_len));

  prd_countdown #(.W(DLY_W)) u_delay (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .load_val(dly_val), .last(dly_last));

  prd_countdown #(.W(BO_W)) u_backoff (
    .clk(clk), .rst_n(rst_n), .load(bo_load), .load_val(BO_W'(BACKOFF)), .last(bo_last));

  always_comb begin
    st_d = st_q;  ptr_d = ptr_q;  rg_addr_d = rg_addr_q;  rg_left_d = rg_left_q;
    cmd_left_d = cmd_left_q;  eot_d = eot_q;  dir_d = dir_q;  back_fetch_d = back_fetch_q;
    done_d = 1'b0;  fault_d = 1'b0;  dly_load = 1'b0;  bo_load = 1'b0;  stat_hit = 1'b0;
    unique case (st_q)
      S_IDLE: if (arm) begin
        st_d       = S_ARMED;
        dir_d      = to_mem;
        cmd_left_d = CMD_W'({cmd_sectors == 8'd0, cmd_sectors}) << SECT_SHIFT;
      end
      S_ARMED: if (go) begin
        st_d  = S_FETCH;
        ptr_d = {table_base[ADDR_W-1:2], 2'b00};
      end
      S_FETCH: begin
        if (mem_busy) begin
          st_d = S_BACK;  back_fetch_d = 1'b1;  bo_load = 1'b1;
        end else st_d = S_FWAIT;
      end
      S_FWAIT: if (mem_ack) begin
        st_d      = S_DELAY;
        rg_addr_d = mem_rdata[31:0];
        rg_left_d = d_len;
        eot_d     = mem_rdata[63];
        ptr_d     = ptr_q + ADDR_W'(DESC_BYTES);
        dly_load  = 1'b1;
      end
      S_DELAY: if (dly_last) st_d = S_BURST;
      S_BURST: begin
        if (mem_busy) begin
          st_d = S_BACK;  back_fetch_d = 1'b0;  bo_load = 1'b1;
        end else st_d = S_BWAIT;
      end
      S_BWAIT: if (mem_ack) begin
        stat_hit   = 1'b1;
        rg_addr_d  = rg_addr_q + ADDR_W'(chunk_len);
        rg_left_d  = rg_left_q - chunk_len;
        cmd_left_d = cmd_left_q - CMD_W'(chunk_len);
        if (!last_chunk)  st_d = S_BURST;
        else if (!eot_q)  st_d = S_FETCH;
        else begin
          st_d    = S_IDLE;
          done_d  = 1'b1;
          fault_d = (cmd_left_q != CMD_W'(chunk_len));
        end
      end
      S_BACK: if (bo_last) st_d = back_fetch_q ? S_FETCH : S_BURST;
      default: st_d = S_IDLE;
    endcase
    if (abort) begin
      st_d = S_IDLE;  done_d = 1'b1;  fault_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;  ptr_q <= '0;  rg_addr_q <= '0;  rg_left_q <= '0;
      cmd_left_q <= '0;  eot_q <= 1'b0;  dir_q <= 1'b0;  back_fetch_q <= 1'b0;
      done <= 1'b0;  fault <= 1'b0;
    end else begin
      st_q <= st_d;  ptr_q <= ptr_d;  rg_addr_q <= rg_addr_d;  rg_left_q <= rg_left_d;
      cmd_left_q <= cmd_left_d;  eot_q <= eot_d;  dir_q <= dir_d;  back_fetch_q <= back_fetch_d;
      done <= done_d;  fault <= fault_d;
    end
  end

  logic [CNT_W-1:0] c_bursts [2];
  logic [CNT_W-1:0] c_bytes  [2];
  logic [CNT_W-1:0] c_pages  [2];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    prd_stats #(.PAGE_BYTES(PAGE_BYTES), .RGN_W(RGN_W), .CNT_W(CNT_W)) u_stats (
      .clk(clk), .rst_n(rst_n), .hit(stat_hit && (dir_q == d[0])), .len(chunk_len),
      .bursts(c_bursts[d]), .bytes(c_bytes[d]), .pages(c_pages[d]));
  end

  assign rd_bursts = c_bursts[0];
  assign rd_bytes  = c_bytes[0];
  assign rd_pages  = c_pages[0];
  assign wr_bursts = c_bursts[1];
  assign wr_bytes  = c_bytes[1];
  assign wr_pages  = c_pages[1];
endmodule

// File: rtl/prd_dma_checker.sv
module prd_dma_checker #(
  parameter int PAGE_BYTES = 4096,
  parameter int ADDR_W     = 32,
  parameter int RGN_W      = 17,
  parameter int CNT_W      = 32,
  localparam int PG_W      = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [RGN_W-1:0]  mem_len,
  input logic              mem_busy,
  input logic              done,
  input logic              fault,
  input logic              issue_due,
  input logic              in_burst,
  input logic              eng_idle,
  input logic [CNT_W-1:0]  rd_bursts,
  input logic [CNT_W-1:0]  wr_bursts
);
  assert_in_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && in_burst |-> (int'(mem_addr[PG_W-1:0]) + int'(mem_len)) <= PAGE_BYTES);

  assert_len_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_len != '0);

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !mem_req);

  assert_backoff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    issue_due && mem_busy |=> !mem_req);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fault_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> done);

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !eng_idle |=> done && fault && eng_idle);

  assert_rd_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_bursts != $past(rd_bursts) |-> rd_bursts == $past(rd_bursts) + 1'b1);

  assert_wr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bursts != $past(wr_bursts) |-> wr_bursts == $past(wr_bursts) + 1'b1);
endmodule

bind prd_dma_engine prd_dma_checker #(
  .PAGE_BYTES(PAGE_BYTES), .ADDR_W(prd_dma_pkg::ADDR_W), .RGN_W(prd_dma_pkg::RGN_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_len(mem_len), .mem_busy(mem_busy), .done(done), .fault(fault),
  .issue_due(issue_due), .in_burst(in_burst), .eng_idle(eng_idle),
  .rd_bursts(rd_bursts), .wr_bursts(wr_bursts)
);

// File: tb/prd_dma_engine_bench.sv
module prd_dma_engine_bench;
  localparam int PER     = 10;
  localparam int DELAY   = 4;
  localparam int BACKOFF = 3;
  localparam int PAGE    = 4096;
  localparam int CNT_W   = 32;
  localparam logic [31:0] TBL = 32'h0000_8000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm = 0, to_mem = 0, go = 0, stop = 0, mem_busy = 0, mem_ack = 0;
  logic [7:0]  cmd_sectors = 0;
  logic [31:0] table_base = 0;
  logic [63:0] mem_rdata = 0;
  logic mem_req, mem_we, done, fault;
  logic [31:0] mem_addr;
  logic [16:0] mem_len;
  logic [CNT_W-1:0] rd_bursts, rd_bytes, rd_pages, wr_bursts, wr_bytes, wr_pages;

  always #(PER/2) clk = ~clk;

  prd_dma_engine #(.DELAY(DELAY), .BACKOFF(BACKOFF), .PAGE_BYTES(PAGE), .CNT_W(CNT_W)) u_prd_dma_engine (
    .clk(clk), .rst_n(rst_n), .arm(arm), .to_mem(to_mem), .cmd_sectors(cmd_sectors),
    .go(go), .table_base(table_base), .stop(stop), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_busy(mem_busy), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .rd_bursts(rd_bursts), .rd_bytes(rd_bytes), .rd_pages(rd_pages),
    .wr_bursts(wr_bursts), .wr_bytes(wr_bytes), .wr_pages(wr_pages));

  typedef struct {
    longint addr; int len; bit we; bit fetch; int dly; bit eotl; bit flt;
  } item_t;

  int checks = 0, errors = 0;
  int cyc = 0, ack_cyc = -100, busy_mod = 0, n_backoff = 0, n_req = 0;
  logic [63:0] dtab [16];
  logic [63:0] rdata_pend = 0;
  item_t q[$];
  bit m_armed = 0, m_active = 0, m_fault = 0, m_dir = 0;
  int m_next = 0, m_done_cyc = -100;
  longint m_cmd_bytes = 0;
  longint e_b[2], e_y[2], e_p[2];
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // memory responder: one-cycle acknowledge, periodic busy pattern
  always @(negedge clk) begin
    mem_ack   = (cyc == ack_cyc);
    mem_rdata = rdata_pend;
    mem_busy  = (busy_mod != 0) && ((cyc % busy_mod) == 0);
  end

  // cycle-by-cycle reference model and comparison
  item_t it;
  bit due, exp_req;
  always begin
    @(negedge clk);
    #(PER/4);
    if (rst_n) begin
      due = m_active && (cyc == m_next);
      exp_req = due && !mem_busy;
      if (due && mem_busy) begin
        m_next = cyc + 1 + BACKOFF;
        n_backoff++;
      end
      if (arm && !m_armed && !m_active && cyc >= m_done_cyc) begin
        m_armed = 1;  m_dir = to_mem;
        m_cmd_bytes = (cmd_sectors == 0 ? 256 : cmd_sectors) * 512;
      end else if (go && m_armed) begin
        m_armed = 0;  m_active = 1;  m_next = cyc + 1;
      end
      if (stop && (m_armed || m_active)) begin
        m_armed = 0;  m_active = 0;  q.delete();
        m_done_cyc = cyc + 1;  m_fault = 1;  exp_req = 0;
      end
      if (mem_req) begin
        n_req++;
        ack_cyc = cyc + 1;
        rdata_pend = (mem_len == 17'd8) ? dtab[((mem_addr - TBL) >> 3) & 15] : 64'd0;
      end
      if (mem_req !== exp_req) chk(0, "R7/R8", "request timing", mem_req, exp_req);
      else checks++;
      if (exp_req && mem_req && q.size() > 0) begin
        it = q.pop_front();
        chk(mem_addr == it.addr[31:0], it.fetch ? "R2" : "R5", "address", mem_addr, it.addr);
        chk(mem_len == it.len, it.fetch ? "R2" : "R5", "length", mem_len, it.len);
        chk(mem_we == it.we, "R6", "direction", mem_we, it.we);
        if (it.fetch) m_next = cyc + 2 + it.dly;
        else begin
          e_b[it.we] += 1;  e_y[it.we] += it.len;
          if (it.len == PAGE) e_p[it.we] += 1;
          if (it.eotl) begin
            m_active = 0;  m_done_cyc = cyc + 2;  m_fault = it.flt;
          end else m_next = cyc + 2;
        end
      end
      chk(done == (cyc == m_done_cyc), "R9", "done", done, cyc == m_done_cyc);
      chk(fault == ((cyc == m_done_cyc) && m_fault), "R9", "fault", fault,
          (cyc == m_done_cyc) && m_fault);
    end
  end

  task automatic build_q(input longint tbl);
    int i = 0, left, c;
    longint tot = 0, a;
    logic [63:0] d;
    item_t f, b;
    q.delete();
    forever begin
      d = dtab[i];
      left = (d[47:32] == 0) ? 65536 : int'(d[47:32]);
      a = longint'(d[31:0]);
      f = '{tbl + 8 * i, 8, 1'b0, 1'b1, DELAY + left / 512, 1'b0, 1'b0};
      q.push_back(f);
      while (left > 0) begin
        c = PAGE - int'(a % PAGE);
        if (c > left) c = left;
        tot += c;  left -= c;
        b = '{a, c, m_dir, 1'b0, 0, (left == 0) && d[63], tot != m_cmd_bytes};
        q.push_back(b);
        a += c;
      end
      if (d[63]) break;
      i++;
    end
  endtask

  task automatic do_arm(input int sect, input bit dir);
    @(negedge clk); arm = 1; cmd_sectors = sect[7:0]; to_mem = dir;
    @(negedge clk); arm = 0;
  endtask

  task automatic do_go(input logic [31:0] base);
    @(negedge clk); go = 1; table_base = base;
    @(negedge clk); go = 0;
  endtask

  task automatic do_stop();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while ((m_active || m_armed || cyc <= m_done_cyc + 1) && n < 3000) begin
      @(negedge clk); n++;
    end
    chk(n < 3000, req, "engine returns to idle", n, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_stats();
    chk(rd_bursts == e_b[0], "R11", "rd_bursts", rd_bursts, e_b[0]);
    chk(rd_bytes  == e_y[0], "R11", "rd_bytes",  rd_bytes,  e_y[0]);
    chk(rd_pages  == e_p[0], "R11", "rd_pages",  rd_pages,  e_p[0]);
    chk(wr_bursts == e_b[1], "R11", "wr_bursts", wr_bursts, e_b[1]);
    chk(wr_bytes  == e_y[1], "R11", "wr_bytes",  wr_bytes,  e_y[1]);
    chk(wr_pages  == e_p[1], "R11", "wr_pages",  wr_pages,  e_p[1]);
  endtask

  initial begin
    #(PER * 100000);
    if (!finished) begin
      chk(0, "R9", "watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) dtab[i] = 64'd0;
    for (int i = 0; i < 2; i++) begin e_b[i] = 0; e_y[i] = 0; e_p[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #(PER/4);
    // R1: reset state
    chk(mem_req == 0 && done == 0 && fault == 0, "R1", "outputs after reset", {mem_req, done, fault}, 0);
    chk(rd_bursts == 0 && rd_bytes == 0 && rd_pages == 0, "R1", "rd counters after reset", rd_bytes, 0);
    chk(wr_bursts == 0 && wr_bytes == 0 && wr_pages == 0, "R1", "wr counters after reset", wr_bytes, 0);

    // R4: go without arm is ignored
    do_go(TBL);
    repeat (10) @(negedge clk);
    chk(n_req == 0, "R4", "requests after unarmed go", n_req, 0);

    // R2 R6: masked base, single region to memory, counts match
    dtab[0] = {1'b1, 15'd0, 16'h0400, 32'h0002_0000};
    do_arm(2, 1); build_q(TBL); do_go(TBL | 32'h3);
    wait_idle("R2"); check_stats();

    // R5 R3: page-crossing region, two descriptors, memory reads
    dtab[0] = {1'b0, 15'd0, 16'h1400, 32'h0003_0E00};
    dtab[1] = {1'b1, 15'd0, 16'h0200, 32'h0004_0000};
    do_arm(11, 0); build_q(TBL); do_go(TBL);
    wait_idle("R5"); check_stats();

    // R8: busy pattern forces backoff and retries
    busy_mod = 3;
    dtab[0] = {1'b0, 15'd0, 16'h2000, 32'h0005_0800};
    dtab[1] = {1'b1, 15'd0, 16'h0600, 32'h0006_0F00};
    do_arm(19, 1); build_q(TBL); do_go(TBL);
    wait_idle("R8"); check_stats();
    chk(n_backoff > 0, "R8", "backoffs exercised", n_backoff, 1);
    busy_mod = 0;

    // R3 R9: zero count means 64 KiB; armed 256 sectors -> mismatch fault
    dtab[0] = {1'b1, 15'd0, 16'h0000, 32'h0010_0000};
    do_arm(0, 1); build_q(TBL); do_go(TBL);
    wait_idle("R9"); check_stats();

    // R10: stop during the region delay
    dtab[0] = {1'b1, 15'd0, 16'h0800, 32'h0020_0000};
    do_arm(4, 0); build_q(TBL); do_go(TBL);
    repeat (3) @(negedge clk);
    do_stop();
    wait_idle("R10"); check_stats();

    // R10: stop while only armed
    do_arm(1, 0);
    do_stop();
    wait_idle("R10");
    repeat (5) @(negedge clk);
    check_stats();

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule